// File: doc/BRIEF.md
# Write-only I2C control register slave for a stereo audio processor

This block sits on a two-wire serial bus as a target that accepts only write transfers. It keeps six 8-bit settings for a two-channel audio signal path and decodes them into named control fields. These fields are the two channel volumes, the two gain codes of the clarity enhancer, the bass and treble codes, and the mute, enhancer, AGC and surround mode flags. A strap input selects one bit of the bus address, so two devices can share the bus.

The serial clock and data lines are sampled by the system clock. Each line passes through a synchroniser and a short glitch filter, and START and STOP are then found from the filtered levels. After the address byte has matched, the next byte picks a register. Every byte after that is stored in turn at rising register numbers. The count stops past the last register and does not wrap. The acknowledge is given by pulling the data line low through an open-drain enable output.

Top module: `audctl_i2c_regs`

## Requirements
- R1: The 7-bit bus address is binary 100000c, where c is the `chipSel` level, and the eighth bit (R/W) must be 0. A matching address byte is acknowledged by driving `sdaPullLow` high during the ninth SCL pulse. Any other address byte gets no acknowledge, and the block ignores the bus until the next START.
- R2: The first byte after an acknowledged address selects a register. The bytes after it are stored at that register, then at register+1, and so on.
- R3: Data bytes that arrive after register 5 has been written are acknowledged and discarded. Register 0 is never written by wrap-around.
- R4: Within one transaction, every byte after the select byte is data, even when its value is a valid register number.
- R5: A select byte above 5 is acknowledged. No register changes until the next START.
- R6: A STOP or a repeated START at any point ends the current transfer. A partly received byte is never written.
- R7: After reset the volumes are 00h and the enhancer gains are 0. Bass and treble are 20h (flat), and all flags and the surround effect code are 0.
- R8: The fields are decoded as follows. Register 0 is `vol1` and register 1 is `vol2`. Register 2 carries `procGain` in [7:4] and `contourGain` in [3:0]. Register 3 carries `enhOn` in [7] and `bassCode` in [6:0]. Register 4 carries `muteOn` in [7] and `trebleCode` in [6:0]. Register 5 carries `agcOn` [7], `surrOn` [6], `stereoSurr` [5], `monoSurr` [4], `loopOn` [3] and `surrEffect` [2:0].
- R9: A pulse on SCL or SDA that is shorter than the filter length (3 system clocks by default) has no effect.
- R10: A register changes only when an acknowledged data byte completes, at the falling SCL edge that ends its acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| chipSel | input | 1 | Strap that sets address bit 0 |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| vol1 | output | 8 | Channel 1 volume code |
| vol2 | output | 8 | Channel 2 volume code |
| procGain | output | 4 | Enhancer process gain code |
| contourGain | output | 4 | Enhancer contour gain code |
| enhOn | output | 1 | Enhancer enable |
| bassCode | output | 7 | Bass tone code |
| muteOn | output | 1 | Output mute |
| trebleCode | output | 7 | Treble tone code |
| agcOn | output | 1 | AGC enable |
| surrOn | output | 1 | Surround enable |
| stereoSurr | output | 1 | Stereo surround mode |
| monoSurr | output | 1 | Mono (pseudo-stereo) surround mode |
| loopOn | output | 1 | Surround loop enhancement |
| surrEffect | output | 3 | Surround effect code |

## Verification
Single-byte writes and bursts that start at several registers separate correct auto-increment from off-by-one pointer errors. Bursts that run past register 5 show that the pointer saturates instead of wrapping. A second byte carrying a valid register number checks that it is stored as data and not taken as a new select. Wrong addresses, the read bit, both strap levels and an out-of-range select cover acknowledge and ignore behaviour. A STOP and a repeated START inside a byte, and short SCL glitches, show that only complete, acknowledged bytes reach the registers.

// File: rtl/audctl_pkg.sv
package audctl_pkg;

  localparam int NUM_REGS   = 6;
  localparam int IDX_W      = 3;
  localparam int DATA_W     = 8;
  localparam int REG_BASS   = 3;
  localparam int REG_TREBLE = 4;
  localparam logic [DATA_W-1:0] TONE_FLAT = 8'h20;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SELECT,
    PH_DATA
  } phase_t;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [DATA_W-1:0] wrData;
  } regStrobe_t;

  function automatic logic [DATA_W-1:0] resetValue(input int idx);
    if (idx == REG_BASS || idx == REG_TREBLE) return TONE_FLAT;
    return '0;
  endfunction

endpackage

// File: rtl/audctl_line_filter.sv
module audctl_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   synced;
  logic [CNT_W-1:0]       stableCnt;

  assign synced = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOut   <= 1'b1;
      stableCnt <= '0;
    end else if (synced == lineOut) begin
      stableCnt <= '0;
    end else if (stableCnt == CNT_W'(FILT_LEN - 1)) begin
      lineOut   <= synced;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  // R9
  filter_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineOut != $past(lineOut)) |-> ($past(synced) == lineOut && $past(synced, 2) == lineOut));

endmodule

// File: rtl/audctl_ctrl.sv
module audctl_ctrl
  import audctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_BASE = 7'b1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic       chipSel,
  output logic       sdaOe,
  output regStrobe_t strobe
);
  logic             sclPrev, sdaPrev;
  logic             sclRise, sclFall, isStart, isStop;
  phase_t           phase;
  logic [3:0]       bitCnt;
  logic [7:0]       shiftQ;
  logic [IDX_W-1:0] ptr;
  logic             ptrValid;
  logic [6:0]       devAddr;
  logic             byteAck;

  assign devAddr = {DEV_ADDR_BASE[6:1], chipSel};
  assign sclRise = sclF & ~sclPrev;
  assign sclFall = ~sclF & sclPrev;
  assign isStart = sclF & sclPrev & sdaPrev & ~sdaF;
  assign isStop  = sclF & sclPrev & ~sdaPrev & sdaF;

  always_comb begin
    if (phase == PH_ADDR) byteAck = (shiftQ[7:1] == devAddr) && !shiftQ[0];
    else                  byteAck = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      shiftQ   <= '0;
      ptr      <= '0;
      ptrValid <= 1'b0;
      sdaOe    <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe.wrEn <= 1'b0;
      if (isStart) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (isStop) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) shiftQ <= {shiftQ[6:0], sdaF};
          if (bitCnt < 4'd9) bitCnt <= bitCnt + 1'b1;
        end else if (sclFall) begin
          if (bitCnt == 4'd8) begin
            if (byteAck) sdaOe <= 1'b1;
            else begin
              phase  <= PH_IDLE;
              bitCnt <= '0;
            end
          end else if (bitCnt == 4'd9) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            unique case (phase)
              PH_ADDR: phase <= PH_SELECT;
              PH_SELECT: begin
                ptr      <= shiftQ[IDX_W-1:0];
                ptrValid <= shiftQ < 8'(NUM_REGS);
                phase    <= PH_DATA;
              end
              PH_DATA: begin
                if (ptrValid) begin
                  strobe.wrEn   <= 1'b1;
                  strobe.wrIdx  <= ptr;
                  strobe.wrData <= shiftQ;
                  if (ptr == IDX_W'(NUM_REGS - 1)) ptrValid <= 1'b0;
                  else                             ptr <= ptr + 1'b1;
                end
              end
              default: phase <= PH_IDLE;
            endcase
          end
        end
      end
    end
  end

  // R1
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (bitCnt >= 4'd8 && phase != PH_IDLE));

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    isStop |=> (phase == PH_IDLE && !sdaOe));

  // R3
  strobe_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (strobe.wrIdx < IDX_W'(NUM_REGS)));

  // R10
  strobe_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> ($past(sdaOe) && !sdaOe));

endmodule

// File: rtl/audctl_regbank.sv
module audctl_regbank
  import audctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strobe,
  output logic [7:0] vol1,
  output logic [7:0] vol2,
  output logic [3:0] procGain,
  output logic [3:0] contourGain,
  output logic       enhOn,
  output logic [6:0] bassCode,
  output logic       muteOn,
  output logic [6:0] trebleCode,
  output logic       agcOn,
  output logic       surrOn,
  output logic       stereoSurr,
  output logic       monoSurr,
  output logic       loopOn,
  output logic [2:0] surrEffect
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= resetValue(i);
    end else if (strobe.wrEn) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (strobe.wrIdx == IDX_W'(i)) regFile[i] <= strobe.wrData;
    end
  end

  assign vol1        = regFile[0];
  assign vol2        = regFile[1];
  assign procGain    = regFile[2][7:4];
  assign contourGain = regFile[2][3:0];
  assign enhOn       = regFile[3][7];
  assign bassCode    = regFile[3][6:0];
  assign muteOn      = regFile[4][7];
  assign trebleCode  = regFile[4][6:0];
  assign agcOn       = regFile[5][7];
  assign surrOn      = regFile[5][6];
  assign stereoSurr  = regFile[5][5];
  assign monoSurr    = regFile[5][4];
  assign loopOn      = regFile[5][3];
  assign surrEffect  = regFile[5][2:0];

  // R10
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(regFile));

endmodule

// File: rtl/audctl_i2c_regs.sv
module audctl_i2c_regs
  import audctl_pkg::*;
#(
  parameter int         SYNC_STAGES   = 2,
  parameter int         FILT_LEN      = 3,
  parameter logic [6:0] DEV_ADDR_BASE = 7'b1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       chipSel,
  output logic       sdaPullLow,
  output logic [7:0] vol1,
  output logic [7:0] vol2,
  output logic [3:0] procGain,
  output logic [3:0] contourGain,
  output logic       enhOn,
  output logic [6:0] bassCode,
  output logic       muteOn,
  output logic [6:0] trebleCode,
  output logic       agcOn,
  output logic       surrOn,
  output logic       stereoSurr,
  output logic       monoSurr,
  output logic       loopOn,
  output logic [2:0] surrEffect
);
  logic [1:0] rawLines, cleanLines;
  regStrobe_t strobe;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_line
    audctl_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (rawLines[g]),
      .lineOut(cleanLines[g])
    );
  end

  audctl_ctrl #(.DEV_ADDR_BASE(DEV_ADDR_BASE)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclF   (cleanLines[0]),
    .sdaF   (cleanLines[1]),
    .chipSel(chipSel),
    .sdaOe  (sdaPullLow),
    .strobe (strobe)
  );

  audctl_regbank u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .vol1       (vol1),
    .vol2       (vol2),
    .procGain   (procGain),
    .contourGain(contourGain),
    .enhOn      (enhOn),
    .bassCode   (bassCode),
    .muteOn     (muteOn),
    .trebleCode (trebleCode),
    .agcOn      (agcOn),
    .surrOn     (surrOn),
    .stereoSurr (stereoSurr),
    .monoSurr   (monoSurr),
    .loopOn     (loopOn),
    .surrEffect (surrEffect)
  );

endmodule

// File: tb/tb_audctl_i2c_regs.sv
`timescale 1ns/1ps
module tb_audctl_i2c_regs;
  localparam int Q      = 10;
  localparam int SETTLE = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, chipSel = 1'b0;
  logic sdaLine, sdaPullLow;
  logic [7:0] vol1, vol2;
  logic [3:0] procGain, contourGain;
  logic enhOn, muteOn, agcOn, surrOn, stereoSurr, monoSurr, loopOn;
  logic [6:0] bassCode, trebleCode;
  logic [2:0] surrEffect;

  always #2 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  audctl_i2c_regs dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .chipSel(chipSel),
    .sdaPullLow(sdaPullLow), .vol1(vol1), .vol2(vol2), .procGain(procGain),
    .contourGain(contourGain), .enhOn(enhOn), .bassCode(bassCode), .muteOn(muteOn),
    .trebleCode(trebleCode), .agcOn(agcOn), .surrOn(surrOn), .stereoSurr(stereoSurr),
    .monoSurr(monoSurr), .loopOn(loopOn), .surrEffect(surrEffect)
  );

  // reference model state
  logic [7:0] expReg [6];
  int  checks = 0, fails = 0;
  int  cycleCnt = 0;
  int  lastChange = 0;
  bit  running = 1'b0;
  bit  done = 1'b0;

  function automatic logic [47:0] actVec();
    return {vol1, vol2, procGain, contourGain, enhOn, bassCode, muteOn, trebleCode,
            agcOn, surrOn, stereoSurr, monoSurr, loopOn, surrEffect};
  endfunction

  function automatic logic [47:0] expVec();
    return {expReg[0], expReg[1], expReg[2], expReg[3], expReg[4], expReg[5]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock comparison against the model, outside the settle window (R8, R10)
  always @(negedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (running && !done && (cycleCnt - lastChange > SETTLE))
      check("R8/R10 per-clock", 64'(actVec()), 64'(expVec()));
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modelWrite(input int idx, input logic [7:0] val);
    expReg[idx] = val;
    lastChange = cycleCnt;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    sdaM = 1'b0; waitCyc(Q);
    sclM = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    sdaM = 1'b1; waitCyc(2 * Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitCyc(Q);
      sclM = 1'b1; waitCyc(2 * Q);
      sclM = 1'b0; waitCyc(Q);
    end
  endtask

  // sends 8 bits and the ack clock; returns with SCL just driven low
  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    acked = (sdaLine == 1'b0);
    waitCyc(Q);
    sclM = 1'b0;
  endtask

  // full write transaction with model update; expAddrAck selects R1 outcome
  task automatic writeTxn(input logic [6:0] addr, input logic rw, input bit expAddrAck,
                          input logic [7:0] sel, input logic [7:0] data[$], input bit doStop);
    bit ack;
    int ptr;
    busStart();
    sendByte({addr, rw}, ack);
    check("R1 address ack", 64'(ack), 64'(expAddrAck));
    waitCyc(Q);
    if (!expAddrAck || !ack) begin
      // remaining bytes must be ignored and unacknowledged
      sendByte(sel, ack);
      check("R1 ignored after mismatch", 64'(ack), 64'(0));
      waitCyc(Q);
      busStop();
      return;
    end
    sendByte(sel, ack);
    check("R2/R5 select ack", 64'(ack), 64'(1));
    waitCyc(Q);
    ptr = (sel < 6) ? int'(sel) : 99;
    foreach (data[k]) begin
      sendByte(data[k], ack);
      check("R3/R4 data ack", 64'(ack), 64'(1));
      if (ptr < 6) begin
        modelWrite(ptr, data[k]);
        ptr++;
      end
      waitCyc(Q);
    end
    if (doStop) busStop();
  endtask

  task automatic checkAll(input string req);
    waitCyc(SETTLE + 2);
    check(req, 64'(actVec()), 64'(expVec()));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d[$];
    bit ack;
    for (int i = 0; i < 6; i++) expReg[i] = (i == 3 || i == 4) ? 8'h20 : 8'h00;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    running = 1'b1;

    // R7 reset state
    check("R7 reset fields", 64'(actVec()), 64'(expVec()));
    check("R7 no ack at reset", 64'(sdaPullLow), 64'(0));

    // R2 single write, strap low
    d = '{8'hB9};
    writeTxn(7'b1000000, 1'b0, 1'b1, 8'd0, d, 1'b1);
    checkAll("R2 single write vol1");

    // R2/R8 burst from register 1 through 5
    d = '{8'h7D, 8'hA5, 8'hC3, 8'hBF, 8'hD6};
    writeTxn(7'b1000000, 1'b0, 1'b1, 8'd1, d, 1'b1);
    checkAll("R8 burst field decode");

    // R3 no wrap: start at 4, four bytes
    d = '{8'h11, 8'h2E, 8'h99, 8'h42};
    writeTxn(7'b1000000, 1'b0, 1'b1, 8'd4, d, 1'b1);
    checkAll("R3 saturate at register 5");
    check("R3 register 0 untouched", 64'(vol1), 64'(8'hB9));

    // R4 a valid register number sent as second byte is data
    d = '{8'h5F, 8'h02, 8'h3A};
    writeTxn(7'b1000000, 1'b0, 1'b1, 8'd0, d, 1'b1);
    checkAll("R4 later bytes are data");
    check("R4 vol2 holds 02h", 64'(vol2), 64'(8'h02));

    // R5 select above 5
    d = '{8'hEE, 8'hDD};
    writeTxn(7'b1000000, 1'b0, 1'b1, 8'd6, d, 1'b1);
    checkAll("R5 out-of-range select");

    // R1 wrong address with strap low, read bit, then strap high
    d = '{8'h00};
    writeTxn(7'b1000001, 1'b0, 1'b0, 8'd0, d, 1'b1);
    checkAll("R1 wrong address no change");
    writeTxn(7'b1000000, 1'b1, 1'b0, 8'd0, d, 1'b1);
    checkAll("R1 read bit rejected");
    chipSel = 1'b1;
    waitCyc(Q);
    writeTxn(7'b1000000, 1'b0, 1'b0, 8'd0, d, 1'b1);
    checkAll("R1 strap high rejects 40h");
    d = '{8'h8C};
    writeTxn(7'b1000001, 1'b0, 1'b1, 8'd1, d, 1'b1);
    checkAll("R1 strap high accepts 41h");

    // R6 STOP inside a data byte
    busStart();
    sendByte({7'b1000001, 1'b0}, ack); waitCyc(Q);
    sendByte(8'd0, ack); waitCyc(Q);
    sendBits(8'hF0, 4);
    busStop();
    checkAll("R6 partial byte then STOP");

    // R6 repeated START inside a byte, then new transfer
    busStart();
    sendByte({7'b1000001, 1'b0}, ack); waitCyc(Q);
    sendByte(8'd0, ack); waitCyc(Q);
    sendBits(8'h0F, 3);
    d = '{8'h77};
    writeTxn(7'b1000001, 1'b0, 1'b1, 8'd1, d, 1'b1);
    checkAll("R6 repeated START mid-byte");
    check("R6 vol1 kept", 64'(vol1), 64'(8'h5F));

    // R6 repeated START after complete byte
    d = '{8'h5A};
    writeTxn(7'b1000001, 1'b0, 1'b1, 8'd2, d, 1'b0);
    d = '{8'hC1};
    writeTxn(7'b1000001, 1'b0, 1'b1, 8'd3, d, 1'b1);
    checkAll("R6 repeated START between writes");

    // R9 short SCL glitches before the first data bit
    busStart();
    sendByte({7'b1000001, 1'b0}, ack); waitCyc(Q);
    sendByte(8'd0, ack); waitCyc(Q);
    sdaM = 1'b0; waitCyc(Q);
    sclM = 1'b1; waitCyc(1); sclM = 1'b0; waitCyc(Q);
    sclM = 1'b1; waitCyc(2); sclM = 1'b0; waitCyc(Q);
    sendByte(8'h3C, ack);
    check("R9 ack after glitches", 64'(ack), 64'(1));
    modelWrite(0, 8'h3C);
    waitCyc(Q);
    busStop();
    checkAll("R9 glitches ignored");
    check("R9 vol1 value", 64'(vol1), 64'(8'h3C));

    done = 1'b1;
    waitCyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule